// File: doc/BRIEF.md
# Miscellaneous System Control Register Block

This block holds a workstation's miscellaneous control state behind a simple single-cycle register port. A main window carries three byte registers (configuration, diagnostic, modem control), a 16-bit diagnostic LED register and a 32-bit system-control word. Two byte registers are reached through their own select lines: an auxiliary function register that fires the floppy terminal-count line, and a software power-down register that holds a sticky power-fail flag. A fourth select reaches a power-management port whose only effect is a CPU halt strobe.

Most registers have side effects. Writes can produce one-cycle pulses (terminal count, power-off, reset request, halt). The power-fail flag is set from an external input and cleared by software. The interrupt output combines that flag with an enable bit held in the configuration register.

Top module: `sysmisc_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every register, `rdata`, `rvalid` and all strobe outputs to zero.
- R2: Main-window accesses (`sel_main`) decode `addr & 0x0fff0000`. The byte registers sit at configuration 0x01800000, diagnostic 0x01a00000 and modem 0x01b00000, take `size`=0 (byte) and store `wdata[7:0]`. An undecoded window offset reads zero, and a write to one changes nothing.
- R3: `size` codes are 0 byte, 1 half, 2 word (3 matches nothing). An access whose size does not match the target register reads zero, and a write with the wrong size is ignored.
- R4: The LED register at 0x01600000 takes half accesses with `addr[0]`=0 and stores `wdata[15:0]`. With `addr[0]`=1 it reads zero and writes are ignored.
- R5: `irq` is high exactly when the power-fail flag (aux2 bit 5) and the configuration enable bit 3 are both set. It updates in the cycle after the edge that changes either one.
- R6: On an edge where `pwr_fail` differs from its value at the previous edge (zero after reset), the flag takes `pwr_fail` AND the enable bit as held before that edge. This takes priority over an aux2 write at the same edge.
- R7: A byte aux2 write (`sel_aux2`) stores bit 0 = `wdata[0]` (power off). The flag is cleared if `wdata[1]` is set and otherwise kept. Aux2 reads return the flag in bit 5 and power off in bit 0.
- R8: A byte aux2 write with `wdata[0]` set raises `pwr_off` for exactly one cycle.
- R9: A byte aux1 write (`sel_aux1`) stores `wdata[7:0]` with bit 1 forced to zero. When `wdata[1]` is set, `fd_tc` pulses for one cycle.
- R10: The system-control word at 0x01f00000 takes word accesses with `addr[1:0]`=0. A write with `wdata[0]` set makes it read 0x2 and pulses `sys_rst_req` for one cycle. Other writes leave it unchanged, and other sub-addresses read zero.
- R11: Any write with `sel_pwr` pulses `cpu_halt` for one cycle. Reads of that port return zero.
- R12: `rvalid` is high in the cycle after `rd_en`, with `rdata` showing the register value from before that edge. `rdata` is zero when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_main | input | 1 | Select main register window |
| sel_aux1 | input | 1 | Select auxiliary function register |
| sel_aux2 | input | 1 | Select power-down register |
| sel_pwr | input | 1 | Select power-management port |
| addr | input | ADDR_W | Access address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| size | input | 2 | Access size code |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| pwr_fail | input | 1 | Power supply failing |
| irq | output | 1 | Power-fail interrupt |
| fd_tc | output | 1 | Floppy terminal-count pulse |
| pwr_off | output | 1 | Power-off request pulse |
| sys_rst_req | output | 1 | System reset request pulse |
| cpu_halt | output | 1 | CPU halt strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit address, the 0x0fff0000 window mask and the default register offsets. Because the mask ignores the top nibble and the low 16 bits, random addresses above and below the decoded field also reach the registers. This exercises the mask as well as the offsets. The low address bits that pick the LED and system-control sub-addresses are drawn at random, and so are the four size codes, so mismatched sizes and the ignored sub-addresses come up often. The `pwr_fail` input toggles at random against aux2 writes, so an input change and a clear can land on the same edge.

// File: rtl/sysmisc_regs.sv
module sysmisc_regs #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_MASK = 32'h0fff_0000,
  parameter logic [31:0] OFS_LED  = 32'h0160_0000,
  parameter logic [31:0] OFS_CFG  = 32'h0180_0000,
  parameter logic [31:0] OFS_DIAG = 32'h01a0_0000,
  parameter logic [31:0] OFS_MDM  = 32'h01b0_0000,
  parameter logic [31:0] OFS_SYS  = 32'h01f0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_main,
  input  logic              sel_aux1,
  input  logic              sel_aux2,
  input  logic              sel_pwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              pwr_fail,
  output logic              irq,
  output logic              fd_tc,
  output logic              pwr_off,
  output logic              sys_rst_req,
  output logic              cpu_halt
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  logic [7:0]  cfg_q, diag_q, mdm_q, aux1_q;
  logic [15:0] led_q;
  logic        sys_q, off_q, pf_q, pf_seen;

  logic [31:0] win;
  assign win = 32'(addr) & WIN_MASK;

  logic hit_cfg, hit_diag, hit_mdm, hit_led, hit_sys, hit_a1, hit_a2;
  assign hit_cfg  = sel_main && win == OFS_CFG  && size == SZ_B;
  assign hit_diag = sel_main && win == OFS_DIAG && size == SZ_B;
  assign hit_mdm  = sel_main && win == OFS_MDM  && size == SZ_B;
  assign hit_led  = sel_main && win == OFS_LED  && size == SZ_H && !addr[0];
  assign hit_sys  = sel_main && win == OFS_SYS  && size == SZ_W && addr[1:0] == 2'b00;
  assign hit_a1   = sel_aux1 && size == SZ_B;
  assign hit_a2   = sel_aux2 && size == SZ_B;

  logic [31:0] rd_mux;
  assign rd_mux = ({32{hit_cfg}}  & {24'd0, cfg_q})
                | ({32{hit_diag}} & {24'd0, diag_q})
                | ({32{hit_mdm}}  & {24'd0, mdm_q})
                | ({32{hit_led}}  & {16'd0, led_q})
                | ({32{hit_sys}}  & {30'd0, sys_q, 1'b0})
                | ({32{hit_a1}}   & {24'd0, aux1_q})
                | ({32{hit_a2}}   & {26'd0, pf_q, 4'd0, off_q});

  assign irq = pf_q & cfg_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0; diag_q <= '0; mdm_q <= '0; aux1_q <= '0; led_q <= '0;
      sys_q <= 1'b0; off_q <= 1'b0; pf_q <= 1'b0; pf_seen <= 1'b0;
      rdata <= '0; rvalid <= 1'b0;
      fd_tc <= 1'b0; pwr_off <= 1'b0; sys_rst_req <= 1'b0; cpu_halt <= 1'b0;
    end else begin
      pf_seen     <= pwr_fail;
      rvalid      <= rd_en;
      rdata       <= rd_en ? rd_mux : 32'd0;
      fd_tc       <= wr_en && hit_a1 && wdata[1];
      pwr_off     <= wr_en && hit_a2 && wdata[0];
      sys_rst_req <= wr_en && hit_sys && wdata[0];
      cpu_halt    <= wr_en && sel_pwr;
      if (wr_en) begin
        if (hit_cfg)  cfg_q  <= wdata[7:0];
        if (hit_diag) diag_q <= wdata[7:0];
        if (hit_mdm)  mdm_q  <= wdata[7:0];
        if (hit_led)  led_q  <= wdata[15:0];
        if (hit_a1)   aux1_q <= wdata[7:0] & 8'hfd;
        if (hit_sys && wdata[0]) sys_q <= 1'b1;
        if (hit_a2) begin
          off_q <= wdata[0];
          if (wdata[1]) pf_q <= 1'b0;
        end
      end
      if (pwr_fail != pf_seen) pf_q <= pwr_fail & cfg_q[3];
    end
  end
endmodule

module sysmisc_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic        sel_aux1,
  input logic        sel_aux2,
  input logic        sel_pwr,
  input logic        sel_main,
  input logic [1:0]  size,
  input logic [31:0] wdata,
  input logic        pwr_fail,
  input logic        rvalid,
  input logic        irq,
  input logic        cfg_en,
  input logic        fd_tc,
  input logic        pwr_off,
  input logic        sys_rst_req,
  input logic        cpu_halt
);
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> cfg_en);
  a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_aux2 && size == 2'd0 && wdata[1] && !pwr_fail) |=> !irq);
  a_r8_off_cause: assert property (@(posedge clk) disable iff (rst)
    pwr_off |-> $past(wr_en && sel_aux2 && size == 2'd0 && wdata[0]));
  a_r9_tc_cause: assert property (@(posedge clk) disable iff (rst)
    fd_tc |-> $past(wr_en && sel_aux1 && size == 2'd0 && wdata[1]));
  a_r10_rst_cause: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(wr_en && sel_main && size == 2'd2 && wdata[0]));
  a_r11_halt_cause: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> $past(wr_en && sel_pwr));
  a_r12_rvalid_cause: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en));
endmodule

bind sysmisc_regs sysmisc_regs_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel_aux1(sel_aux1),
  .sel_aux2(sel_aux2), .sel_pwr(sel_pwr), .sel_main(sel_main), .size(size),
  .wdata(wdata), .pwr_fail(pwr_fail), .rvalid(rvalid), .irq(irq),
  .cfg_en(cfg_q[3]), .fd_tc(fd_tc), .pwr_off(pwr_off),
  .sys_rst_req(sys_rst_req), .cpu_halt(cpu_halt));

// File: tb/sysmisc_regs_tb_top.sv
`timescale 1ns/1ps
module sysmisc_regs_tb_top;
  localparam logic [31:0] A_LED = 32'h0160_0000, A_CFG = 32'h0180_0000,
    A_DIAG = 32'h01a0_0000, A_MDM = 32'h01b0_0000, A_SYS = 32'h01f0_0000;

  logic clk = 0, rst = 1;
  logic sel_main = 0, sel_aux1 = 0, sel_aux2 = 0, sel_pwr = 0;
  logic [31:0] addr = 0, wdata = 0, rdata;
  logic wr_en = 0, rd_en = 0, pwr_fail = 0;
  logic [1:0] size = 0;
  logic rvalid, irq, fd_tc, pwr_off, sys_rst_req, cpu_halt;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sysmisc_regs dut_i (.clk(clk), .rst(rst), .sel_main(sel_main), .sel_aux1(sel_aux1),
    .sel_aux2(sel_aux2), .sel_pwr(sel_pwr), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pwr_fail(pwr_fail),
    .irq(irq), .fd_tc(fd_tc), .pwr_off(pwr_off), .sys_rst_req(sys_rst_req),
    .cpu_halt(cpu_halt));

  logic [7:0] m_cfg, m_diag, m_mdm, m_aux1;
  logic [15:0] m_led;
  logic m_sys, m_off, m_pf, m_seen;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic sm, logic s1, logic s2,
      logic [31:0] a, logic [1:0] sz);
    logic [31:0] w = a & 32'h0fff_0000;
    logic [31:0] v = 0;
    if (sm && sz == 0 && w == A_CFG)  v |= {24'd0, m_cfg};
    if (sm && sz == 0 && w == A_DIAG) v |= {24'd0, m_diag};
    if (sm && sz == 0 && w == A_MDM)  v |= {24'd0, m_mdm};
    if (sm && sz == 1 && w == A_LED && !a[0]) v |= {16'd0, m_led};
    if (sm && sz == 2 && w == A_SYS && a[1:0] == 0) v |= {30'd0, m_sys, 1'b0};
    if (s1 && sz == 0) v |= {24'd0, m_aux1};
    if (s2 && sz == 0) v |= {26'd0, m_pf, 4'd0, m_off};
    return v;
  endfunction

  task automatic op(logic sm, logic s1, logic s2, logic sp, logic [31:0] a,
      logic w, logic r, logic [1:0] sz, logic [31:0] wd, logic pfin);
    logic [31:0] w_ofs = a & 32'h0fff_0000;
    logic [31:0] exp_rd;
    logic e_tc, e_off, e_rst, e_halt, old_en;
    @(negedge clk);
    sel_main = sm; sel_aux1 = s1; sel_aux2 = s2; sel_pwr = sp; addr = a;
    wr_en = w; rd_en = r; size = sz; wdata = wd; pwr_fail = pfin;
    exp_rd = r ? model_read(sm, s1, s2, a, sz) : 32'd0;
    old_en = m_cfg[3];
    e_tc = w && s1 && sz == 0 && wd[1];
    e_off = w && s2 && sz == 0 && wd[0];
    e_rst = w && sm && sz == 2 && w_ofs == A_SYS && a[1:0] == 0 && wd[0];
    e_halt = w && sp;
    if (w) begin
      if (sm && sz == 0 && w_ofs == A_CFG)  m_cfg = wd[7:0];
      if (sm && sz == 0 && w_ofs == A_DIAG) m_diag = wd[7:0];
      if (sm && sz == 0 && w_ofs == A_MDM)  m_mdm = wd[7:0];
      if (sm && sz == 1 && w_ofs == A_LED && !a[0]) m_led = wd[15:0];
      if (e_rst) m_sys = 1;
      if (s1 && sz == 0) m_aux1 = wd[7:0] & 8'hfd;
      if (s2 && sz == 0) begin m_off = wd[0]; if (wd[1]) m_pf = 0; end
    end
    if (pfin != m_seen) m_pf = pfin & old_en;
    m_seen = pfin;
    @(posedge clk); #1;
    check("R12 rvalid", {31'd0, rvalid}, {31'd0, r});
    check("R2/R3/R4/R7/R9/R10/R11 rdata", rdata, exp_rd);
    check("R9 fd_tc", {31'd0, fd_tc}, {31'd0, e_tc});
    check("R8 pwr_off", {31'd0, pwr_off}, {31'd0, e_off});
    check("R10 sys_rst_req", {31'd0, sys_rst_req}, {31'd0, e_rst});
    check("R11 cpu_halt", {31'd0, cpu_halt}, {31'd0, e_halt});
    check("R5/R6 irq", {31'd0, irq}, {31'd0, m_pf & m_cfg[3]});
    wr_en = 0; rd_en = 0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_led = 0;
    m_sys = 0; m_off = 0; m_pf = 0; m_seen = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata reset", rdata, 0);
    check("R1 strobes reset", {27'd0, irq, fd_tc, pwr_off, sys_rst_req, cpu_halt}, 0);
    @(negedge clk); rst = 0;
    // R1 registers read zero after reset
    op(1,0,0,0, A_CFG, 0,1, 0, 0, 0);
    op(1,0,0,0, A_SYS, 0,1, 2, 0, 0);
    op(0,0,1,0, 0, 0,1, 0, 0, 0);
    // R2 byte registers, mask ignores top nibble and low half
    op(1,0,0,0, 32'hf180_1234, 1,0, 0, 32'h5a, 0);
    op(1,0,0,0, A_CFG, 0,1, 0, 0, 0);
    op(1,0,0,0, A_DIAG, 1,1, 0, 32'h1c3, 0);
    op(1,0,0,0, A_MDM, 1,0, 0, 32'ha5, 0);
    op(1,0,0,0, A_MDM, 0,1, 0, 0, 0);
    op(1,0,0,0, 32'h0170_0000, 1,1, 0, 32'hff, 0);
    // R3 wrong size
    op(1,0,0,0, A_DIAG, 1,0, 2, 32'h77, 0);
    op(1,0,0,0, A_DIAG, 0,1, 0, 0, 0);
    op(1,0,0,0, A_DIAG, 0,1, 1, 0, 0);
    // R4 LEDs
    op(1,0,0,0, A_LED, 1,0, 1, 32'h1beef, 0);
    op(1,0,0,0, A_LED | 1, 1,1, 1, 32'h1111, 0);
    op(1,0,0,0, A_LED, 0,1, 1, 0, 0);
    // R9 terminal count
    op(0,1,0,0, 0, 1,0, 0, 32'hff, 0);
    op(0,1,0,0, 0, 0,1, 0, 0, 0);
    // R5 R6 R7 power fail and clear
    op(1,0,0,0, A_CFG, 1,0, 0, 32'h08, 0);
    op(0,0,0,0, 0, 0,0, 0, 0, 1);
    op(0,0,1,0, 0, 0,1, 0, 0, 1);
    op(0,0,1,0, 0, 1,1, 0, 32'h02, 1);
    op(0,0,1,0, 0, 0,1, 0, 0, 1);
    op(0,0,0,0, 0, 0,0, 0, 0, 0);
    op(0,0,1,0, 0, 1,0, 0, 32'h02, 1);
    // R8 power off
    op(0,0,1,0, 0, 1,0, 0, 32'h01, 1);
    op(0,0,1,0, 0, 0,1, 0, 0, 1);
    // R10 system control
    op(1,0,0,0, A_SYS, 1,1, 2, 32'h0, 1);
    op(1,0,0,0, A_SYS | 4, 1,0, 2, 32'h1, 1);
    op(1,0,0,0, A_SYS, 1,0, 2, 32'h1, 1);
    op(1,0,0,0, A_SYS, 0,1, 2, 0, 1);
    op(1,0,0,0, A_SYS | 2, 0,1, 2, 0, 1);
    // R11 power port
    op(0,0,0,1, 0, 1,1, 0, 32'hff, 0);
    op(0,0,0,1, 0, 0,1, 2, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [2:0] pick = 3'($urandom % 6);
      logic [2:0] s = 3'($urandom % 5);
      case (pick)
        0: a = A_LED; 1: a = A_CFG; 2: a = A_DIAG;
        3: a = A_MDM; 4: a = A_SYS; default: a = $urandom & 32'h0fff_0000;
      endcase
      a = a | ($urandom & 32'hf000_0003);
      op(s == 0, s == 1, s == 2, s == 3, a, 1'($urandom), 1'($urandom),
         2'($urandom), $urandom,
         ($urandom % 8 == 0) ? ~pwr_fail : pwr_fail);
    end
    finish_run();
  end
endmodule